// File: doc/BRIEF.md
# SPI Master with Two-Bit Transaction Prefix

This block is a register-driven SPI master for a small microcontroller bus. Software writes the serial clock divisor, the clock polarity and phase, the chip-select line to use, the number of bytes to exchange and, optionally, two leading bits that go out ahead of the payload. A start command then runs one complete transaction on its own. The block asserts the chosen chip select, shifts out the prefix bits if they are enabled, exchanges the programmed number of bytes most significant bit first, releases chip select and raises a completion interrupt.

Transmit bytes are taken from a byte-wide input. A one-cycle pulse marks each byte as it is captured, so the host can present the next byte. Each received byte appears on a byte-wide output together with a one-cycle valid pulse. The serial clock is the system clock divided by one of four fixed ratios.

Register map, with byte addresses: 0x00 is the mode register (bits [1:0] divisor code, bit 2 prefix enable, bit 3 first prefix bit, bit 4 second prefix bit, bit 5 CPOL, bit 6 CPHA). 0x01 is the select register (bits [1:0] chip-select code, bit 2 interrupt enable). 0x02 holds the byte count. 0x03 is the command register: writing it with bit 0 set starts a transaction, and reading it returns busy in bit 0 and interrupt pending in bit 1. Any write to 0x10 clears a pending interrupt. All other addresses read as zero.

Top module: `spi_lead_master`

## Requirements
- R1: After reset the mode register reads 0x60 (divisor code 00, prefix off, both prefix bits 0, CPOL 1, CPHA 1), the select register reads 0x06 (chip-select code 10, interrupt enable 1), the byte count reads 0 and the command register reads 0. All chip selects are high, SCLK is high and irq is low.
- R2: Every SCLK half period lasts 2, 6, 8 or 10 system clocks for divisor codes 00, 01, 10 and 11, so the full period is 4, 12, 16 or 20 clocks.
- R3: Between transactions SCLK rests at the CPOL level. A transaction makes exactly 2·N SCLK transitions, where N is 8 times the byte count plus 2 when the prefix is enabled.
- R4: With the prefix enabled, the first two bits on MOSI are the first prefix bit and then the second prefix bit, ahead of any payload. With the prefix disabled, the payload starts at the first bit.
- R5: Payload bytes are taken from tx_data, one per tx_take pulse, and sent most significant bit first in the order they are taken.
- R6: Each group of 8 payload bits sampled on MISO is presented on rx_data with a one-cycle rx_valid pulse, first bit received in bit 7. MISO bits sampled during the prefix are discarded, and exactly one byte is presented per counted byte.
- R7: With CPHA=0 each bit is on MOSI before its leading SCLK edge, and MISO is sampled on that leading edge. With CPHA=1, MOSI changes on the leading edge and MISO is sampled on the trailing edge. Within a transaction MOSI changes only together with an SCLK transition, except for the first bit in CPHA=0.
- R8: Chip-select code 00 drives cs_n[0] low, 01 drives cs_n[1] low, and both 10 and 11 drive cs_n[2] low. Only that line is low, from one half period before the first SCLK transition until one half period after the last one.
- R9: A start command with the byte count at 0 does nothing: chip selects stay high, busy stays 0 and no interrupt is raised.
- R10: Busy reads 1 from the clock after the start command until chip select is released. While busy, further start commands and writes to the mode, select and count registers are ignored.
- R11: When the interrupt enable is 1, irq goes high in the cycle chip select is released and stays high until a write to 0x10. If that write falls in the same clock as a completion, the interrupt stays set. With the enable at 0, completion leaves irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| tx_data | input | 8 | Next payload byte to transmit |
| tx_take | output | 1 | One-cycle pulse: tx_data has been captured |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse: rx_data is new |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 3 | Active-low chip selects |
| irq | output | 1 | Completion interrupt |

## Verification
Two functions can act on the interrupt pending flag in the same clock: completion setting it and a software write to 0x10 clearing it. The bench first leaves an interrupt pending. From the divisor and the bit count it then computes the exact clock of the next completion, 2·N+1 half periods after the start edge, and times the clear write to land one clock early, in that same clock, or one clock late. It expects irq high in the first two cases and low in the third. That the third case reads low also shows that the timing was computed correctly.

// File: rtl/spi_lead_master.sv
module spi_lead_master (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [7:0] tx_data,
  output logic       tx_take,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso,
  output logic [2:0] cs_n,
  output logic       irq
);
  localparam logic [7:0] A_MODE = 8'h00;
  localparam logic [7:0] A_SEL  = 8'h01;
  localparam logic [7:0] A_LEN  = 8'h02;
  localparam logic [7:0] A_CMD  = 8'h03;
  localparam logic [7:0] A_CLR  = 8'h10;
  localparam int CW = 4;
  localparam int EW = 12;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_HOLD} st_t;
  st_t st;

  logic [1:0] div_sel, cs_sel;
  logic       lead_en, lead_a, lead_b, cpol, cpha, irq_en;
  logic [7:0] len;

  logic [CW-1:0] cnt, half_m1;
  logic [EW-1:0] edge_cnt, edge_last;
  logic [1:0]    tx_pre, rx_pre, pre_sr;
  logic [2:0]    tx_bit, rx_bit;
  logic [7:0]    tx_sr, rx_sr;
  logic          sclk_r, mosi_r, irq_r, take_r, rvalid_r;
  logic [7:0]    rdata_r;
  logic [2:0]    cs_r, cs_dec;

  logic busy, tick, start_go, run_edge, smp, drv;
  logic [1:0] d_pre, d_sr;
  logic [2:0] d_bit;

  always_comb
    case (div_sel)
      2'b00:   half_m1 = CW'(1);
      2'b01:   half_m1 = CW'(5);
      2'b10:   half_m1 = CW'(7);
      default: half_m1 = CW'(9);
    endcase

  always_comb
    case (cs_sel)
      2'b00:   cs_dec = 3'b110;
      2'b01:   cs_dec = 3'b101;
      default: cs_dec = 3'b011;
    endcase

  assign busy     = (st != S_IDLE);
  assign tick     = busy && (cnt == '0);
  assign start_go = reg_we && (reg_addr == A_CMD) && reg_wdata[0] && !busy && (len != 8'd0);
  assign run_edge = (st == S_RUN) && tick;
  assign smp      = run_edge && (edge_cnt[0] == cpha);
  assign drv      = (start_go && !cpha) ||
                    (run_edge && (cpha ? !edge_cnt[0] : (edge_cnt[0] && edge_cnt != edge_last)));

  assign d_pre = start_go ? (lead_en ? 2'd2 : 2'd0) : tx_pre;
  assign d_sr  = start_go ? {lead_a, lead_b} : pre_sr;
  assign d_bit = start_go ? 3'd0 : tx_bit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_sel <= 2'b00; lead_en <= 1'b0; lead_a <= 1'b0; lead_b <= 1'b0;
      cpol <= 1'b1; cpha <= 1'b1; cs_sel <= 2'b10; irq_en <= 1'b1; len <= 8'd0;
    end else if (reg_we && !busy) begin
      case (reg_addr)
        A_MODE: begin
          div_sel <= reg_wdata[1:0]; lead_en <= reg_wdata[2];
          lead_a <= reg_wdata[3]; lead_b <= reg_wdata[4];
          cpol <= reg_wdata[5]; cpha <= reg_wdata[6];
        end
        A_SEL: begin cs_sel <= reg_wdata[1:0]; irq_en <= reg_wdata[2]; end
        A_LEN: len <= reg_wdata;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; edge_cnt <= '0; edge_last <= '0;
      sclk_r <= 1'b1; mosi_r <= 1'b0; cs_r <= 3'b111; irq_r <= 1'b0;
      take_r <= 1'b0; rvalid_r <= 1'b0; rdata_r <= 8'd0;
      tx_pre <= 2'd0; rx_pre <= 2'd0; pre_sr <= 2'd0;
      tx_bit <= 3'd0; rx_bit <= 3'd0; tx_sr <= 8'd0; rx_sr <= 8'd0;
    end else begin
      take_r   <= 1'b0;
      rvalid_r <= 1'b0;
      if (reg_we && reg_addr == A_CLR) irq_r <= 1'b0;
      case (st)
        S_IDLE: begin
          sclk_r <= cpol;
          if (start_go) begin
            st        <= S_RUN;
            cnt       <= half_m1;
            edge_cnt  <= '0;
            edge_last <= {len, 4'b0000} + (lead_en ? EW'(4) : EW'(0)) - EW'(1);
            cs_r      <= cs_dec;
            tx_pre    <= lead_en ? 2'd2 : 2'd0;
            pre_sr    <= {lead_a, lead_b};
            tx_bit    <= 3'd0;
            rx_pre    <= lead_en ? 2'd2 : 2'd0;
            rx_bit    <= 3'd0;
          end
        end
        S_RUN:
          if (tick) begin
            cnt      <= half_m1;
            sclk_r   <= ~sclk_r;
            edge_cnt <= edge_cnt + EW'(1);
            if (edge_cnt == edge_last) st <= S_HOLD;
          end else cnt <= cnt - CW'(1);
        default:
          if (tick) begin
            st   <= S_IDLE;
            cs_r <= 3'b111;
            if (irq_en) irq_r <= 1'b1;
          end else cnt <= cnt - CW'(1);
      endcase

      if (drv) begin
        if (d_pre != 2'd0) begin
          mosi_r <= d_sr[1];
          pre_sr <= {d_sr[0], 1'b0};
          tx_pre <= d_pre - 2'd1;
        end else if (d_bit == 3'd0) begin
          mosi_r <= tx_data[7];
          tx_sr  <= {tx_data[6:0], 1'b0};
          take_r <= 1'b1;
          tx_bit <= 3'd1;
        end else begin
          mosi_r <= tx_sr[7];
          tx_sr  <= {tx_sr[6:0], 1'b0};
          tx_bit <= d_bit + 3'd1;
        end
      end

      if (smp) begin
        if (rx_pre != 2'd0) rx_pre <= rx_pre - 2'd1;
        else begin
          rx_sr  <= {rx_sr[6:0], miso};
          rx_bit <= rx_bit + 3'd1;
          if (rx_bit == 3'd7) begin
            rdata_r  <= {rx_sr[6:0], miso};
            rvalid_r <= 1'b1;
          end
        end
      end
    end

  always_comb
    case (reg_addr)
      A_MODE:  reg_rdata = {1'b0, cpha, cpol, lead_b, lead_a, lead_en, div_sel};
      A_SEL:   reg_rdata = {5'b0, irq_en, cs_sel};
      A_LEN:   reg_rdata = len;
      A_CMD:   reg_rdata = {6'b0, irq_r, busy};
      default: reg_rdata = 8'd0;
    endcase

  assign sclk     = sclk_r;
  assign mosi     = mosi_r;
  assign cs_n     = cs_r;
  assign irq      = irq_r;
  assign tx_take  = take_r;
  assign rx_data  = rdata_r;
  assign rx_valid = rvalid_r;

  p_cs_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_r) <= 1);
  p_cs_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_r == 3'b111);
  p_idle_sclk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> sclk_r == $past(cpol));
  p_mosi_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && mosi_r != $past(mosi_r)) |-> sclk_r != $past(sclk_r));
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (len == $past(len) && cpha == $past(cpha)));
  p_len0_noop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CMD && reg_wdata[0] && !busy && len == 8'd0) |=> !busy);
  p_irq_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && tick && irq_en) |=> irq_r);
endmodule

// File: tb/spi_lead_master_bench.sv
module spi_lead_master_bench;
  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, miso = 1'b0;
  logic [7:0] reg_addr = 8'h03, reg_wdata = 8'h00, tx_data = 8'h00;
  logic [7:0] reg_rdata, rx_data;
  logic tx_take, rx_valid, sclk, mosi, irq;
  logic [2:0] cs_n;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  spi_lead_master u_spi_lead_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_data(tx_data),
    .tx_take(tx_take), .rx_data(rx_data), .rx_valid(rx_valid),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .irq(irq));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] txb(input int s, input int j);
    return 8'(s * 37 + j * 91 + 5);
  endfunction

  function automatic logic sbit(input int s, input int k);
    return ((s * 7 + k * k + 3 * k) % 5) < 2;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_addr = 8'h03;
  endtask

  task automatic xfer(input int dsel, input int cp, input int ph, input int ld,
                      input int la, input int lb, input int cs, input int ln,
                      input int s, input int ien, input bit poke, input int clr_off);
    int h, pre, n, ce, cyc, last, edges, bad_iv, k, tj, rxn;
    logic prev_sclk, lead, b;
    logic [7:0] cur, ev;
    logic [2:0] exp_cs;
    h   = (dsel == 0) ? 2 : (dsel == 1) ? 6 : (dsel == 2) ? 8 : 10;
    pre = ld ? 2 : 0;
    n   = 8 * ln + pre;
    ce  = (2 * n + 1) * h;
    wr(8'h00, 8'((ph << 6) | (cp << 5) | (lb << 4) | (la << 3) | (ld << 2) | dsel));
    wr(8'h01, 8'((ien << 2) | cs));
    wr(8'h02, 8'(ln));
    @(negedge clk);
    chk(sclk == 1'(cp), "R3 sclk idle before start", sclk, cp);
    tx_data = txb(s, 0); tj = 1;
    k = 0; miso = sbit(s, 0);
    wr(8'h03, 8'h01);
    exp_cs = (cs == 0) ? 3'b110 : (cs == 1) ? 3'b101 : 3'b011;
    chk(cs_n == exp_cs, "R8 chip select decode", cs_n, exp_cs);
    chk(reg_rdata[0] == 1'b1, "R10 busy during transfer", reg_rdata[0], 1);
    if (tx_take) begin tx_data = txb(s, tj); tj++; end
    cyc = 0; last = 0; edges = 0; bad_iv = 0; rxn = 0; cur = 8'd0;
    prev_sclk = sclk;
    while (1) begin
      @(negedge clk); cyc++;
      if (poke && cyc == 5) begin reg_we = 1'b1; reg_addr = 8'h03; reg_wdata = 8'h01; end
      if (poke && cyc == 6) begin reg_addr = 8'h02; reg_wdata = 8'(ln + 7); end
      if (poke && cyc == 7) begin reg_we = 1'b0; reg_addr = 8'h03; end
      if (clr_off > -5 && cyc == ce - 1 + clr_off) begin reg_we = 1'b1; reg_addr = 8'h10; reg_wdata = 8'h00; end
      if (clr_off > -5 && cyc == ce + clr_off) begin reg_we = 1'b0; reg_addr = 8'h03; end
      if (tx_take) begin tx_data = txb(s, tj); tj++; end
      if (rx_valid) begin
        ev = 8'd0;
        for (int i = 0; i < 8; i++) ev = {ev[6:0], sbit(s, pre + 8 * rxn + i)};
        chk(rx_data == ev, "R6 received byte", rx_data, ev);
        rxn++;
      end
      if (sclk != prev_sclk) begin
        edges++;
        if (edges == 1) chk(cyc - last == h, "R8 cs setup half period", cyc - last, h);
        else if (cyc - last != h) bad_iv++;
        last = cyc;
        lead = (sclk != 1'(cp));
        if (ph ? !lead : lead) begin
          b = mosi;
          if (k < pre) chk(b == ((k == 0) ? 1'(la) : 1'(lb)), "R4 prefix bit", b, (k == 0) ? la : lb);
          else begin
            cur = {cur[6:0], b};
            if ((k - pre) % 8 == 7)
              chk(cur == txb(s, (k - pre) / 8), "R5 R7 transmitted byte", cur, txb(s, (k - pre) / 8));
          end
          k++;
          miso = sbit(s, k);
        end
        prev_sclk = sclk;
      end
      if (cs_n == 3'b111 || cyc > 60000) break;
    end
    @(negedge clk); reg_we = 1'b0; reg_addr = 8'h03;
    #1;
    chk(edges == 2 * n, "R3 edge count", edges, 2 * n);
    chk(bad_iv == 0, "R2 half period", bad_iv, 0);
    chk(cyc - last == h, "R8 cs hold half period", cyc - last, h);
    chk(cyc == ce, "R8 completion cycle", cyc, ce);
    chk(sclk == 1'(cp), "R3 sclk idle after", sclk, cp);
    chk(rxn == ln, "R6 byte count", rxn, ln);
    chk(reg_rdata[0] == 1'b0, "R10 busy clear after", reg_rdata[0], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int idx, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reg_addr = 8'h00; #1 chk(reg_rdata == 8'h60, "R1 mode reset", reg_rdata, 8'h60);
    reg_addr = 8'h01; #1 chk(reg_rdata == 8'h06, "R1 select reset", reg_rdata, 8'h06);
    reg_addr = 8'h02; #1 chk(reg_rdata == 8'h00, "R1 length reset", reg_rdata, 0);
    reg_addr = 8'h03; #1 chk(reg_rdata == 8'h00, "R1 command reset", reg_rdata, 0);
    chk(cs_n == 3'b111, "R1 cs reset", cs_n, 7);
    chk(sclk == 1'b1, "R1 sclk reset", sclk, 1);
    chk(irq == 1'b0, "R1 irq reset", irq, 0);

    for (int d = 0; d < 4; d++)
      for (int cp = 0; cp < 2; cp++)
        for (int ph = 0; ph < 2; ph++)
          for (int ld = 0; ld < 2; ld++) begin
            idx = d * 8 + cp * 4 + ph * 2 + ld;
            xfer(d, cp, ph, ld, (idx % 3 == 0), (idx % 5 < 2), idx % 4, 1 + idx % 3, idx, 1, 1'b0, -9);
            chk(irq == 1'b1, "R11 irq on completion", irq, 1);
            wr(8'h10, 8'h00);
            chk(irq == 1'b0, "R11 irq cleared", irq, 0);
          end

    xfer(0, 0, 0, 1, 1, 0, 1, 255, 77, 1, 1'b0, -9);
    wr(8'h10, 8'h00);

    wr(8'h02, 8'h00);
    wr(8'h03, 8'h01);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cs_n != 3'b111 || reg_rdata[0] != 1'b0 || irq != 1'b0) bad++;
    end
    chk(bad == 0, "R9 zero length is a no-op", bad, 0);

    xfer(1, 1, 0, 0, 0, 0, 2, 1, 5, 0, 1'b0, -9);
    chk(irq == 1'b0, "R11 irq disabled", irq, 0);

    xfer(0, 0, 1, 1, 0, 1, 3, 2, 9, 1, 1'b1, -9);
    reg_addr = 8'h02; #1 chk(reg_rdata == 8'd2, "R10 length write ignored while busy", reg_rdata, 2);
    reg_addr = 8'h03;

    xfer(2, 0, 0, 0, 0, 0, 0, 1, 11, 1, 1'b0, 0);
    chk(irq == 1'b1, "R11 set wins over same-cycle clear", irq, 1);
    xfer(3, 1, 1, 1, 1, 1, 1, 1, 12, 1, 1'b0, -1);
    chk(irq == 1'b1, "R11 clear one cycle early then set", irq, 1);
    xfer(1, 0, 1, 0, 0, 0, 2, 1, 13, 1, 1'b0, 1);
    chk(irq == 1'b0, "R11 clear one cycle after completion", irq, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule